// File: doc/BRIEF.md
# DMA Page-Register Address Generator

This block keeps the page bytes that extend a four-channel DMA controller's 16-bit addresses into physical memory. Software reaches these bytes through two small byte-wide port windows, one for the low page byte and one for the high page byte. Within a window, the port offset selects the channel through a sparse map that is not in order, and some offsets lead to no register at all.

On the transfer side, the engine names a channel and supplies that channel's current 16-bit address, its direction bit, and a position/length pair. The block joins the selected channel's page bytes to the current address to form a 31-bit physical address. From that it returns the start address of the burst. In increment direction the burst starts at the position past the physical address. In decrement direction it starts below the physical address by the position plus the length.

A parameter can leave out the high page byte entirely. The address output is combinational. Page writes take effect on the next clock edge.

Top module: `dma_page_addr_gen`

## Requirements
- R1: Within each window, port offset `pg_offs` 7 selects channel 0, offset 3 selects channel 1, offset 1 selects channel 2 and offset 2 selects channel 3. `pg_sel_hi`=0 selects the low page window and `pg_sel_hi`=1 selects the high page window.
- R2: A write with `pg_offs` equal to 0, 4, 5 or 6 changes no page register in either window.
- R3: `pg_rdata` is 0 whenever `pg_offs` is 0, 4, 5 or 6.
- R4: A write with `pg_we`=1 to a valid offset is stored at the rising clock edge. From then on, `pg_rdata` combinationally returns the stored byte for the same window and offset.
- R5: While `rst_n` is low, all eight page registers clear to zero.
- R6: The physical address is {high page bits 6:0, low page byte, `cur_addr`} of the channel named by `burst_chan`, so bit 7 of the high page never reaches the address.
- R7: With `dec_mode`=0, `burst_addr` is the physical address plus `xfer_pos`, modulo 2^31.
- R8: With `dec_mode`=1, `burst_addr` is the physical address minus `xfer_pos` minus `xfer_len`, modulo 2^31.
- R9: With `HI_PAGE_EN`=0, high-window reads return 0, high-window writes are dropped, and bits 30:24 of the physical address are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pg_we | input | 1 | Page port write strobe |
| pg_sel_hi | input | 1 | Window select: 0 low page, 1 high page |
| pg_offs | input | 3 | Port offset within the window |
| pg_wdata | input | 8 | Page write byte |
| pg_rdata | output | 8 | Page read byte for the selected window and offset |
| burst_chan | input | 2 | Channel whose address is being formed |
| cur_addr | input | ADDR_W | Channel's current 16-bit address |
| dec_mode | input | 1 | Direction: 1 means address decrement |
| xfer_pos | input | POS_W | Position within the transfer |
| xfer_len | input | POS_W | Length of the burst |
| burst_addr | output | 31 | Burst start physical address |

## Verification
The readback property assumes that after a write the bench holds the window and offset steady for one more cycle, or else it makes no claim. The write task does this by dropping the strobe on the following falling edge while leaving the port selection unchanged. The pass-through properties assume that the position and length inputs describe the burst in the same cycle as the address. The stimulus changes all address-side inputs together on a falling edge and samples between edges. The sweeps visit every window and offset pair, both directions, and every channel, and include pages with bit 7 set as well as values that wrap across 2^31.

// File: rtl/dma_page_pkg.sv
package dma_page_pkg;

    localparam int NUM_CH      = 4;
    localparam int CH_W        = $clog2(NUM_CH);
    localparam int PAGE_W      = 8;
    localparam int HI_KEEP_W   = 7;
    localparam int PORT_OFFS_W = 3;

    typedef logic [NUM_CH-1:0][PAGE_W-1:0] page_array_t;

    typedef struct packed {
        page_array_t lo;
        page_array_t hi;
    } page_state_t;

    typedef struct packed {
        logic            valid;
        logic [CH_W-1:0] ch;
    } port_map_t;

    // Sparse offset-to-channel map; unlisted offsets lead nowhere.
    function automatic port_map_t map_port(input logic [PORT_OFFS_W-1:0] offs);
        port_map_t m;
        m.valid = 1'b1;
        m.ch    = '0;
        case (offs)
            3'd7:    m.ch = 2'd0;
            3'd3:    m.ch = 2'd1;
            3'd1:    m.ch = 2'd2;
            3'd2:    m.ch = 2'd3;
            default: m.valid = 1'b0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/page_port_decode.sv
module page_port_decode
    import dma_page_pkg::*;
(
    input  logic [PORT_OFFS_W-1:0] offs,
    output port_map_t              map
);

    always_comb begin
        map = map_port(offs);
    end

endmodule

// File: rtl/page_reg_bank.sv
module page_reg_bank
    import dma_page_pkg::*;
#(
    parameter int HI_PAGE_EN = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 win_hi,
    input  port_map_t            port_map,
    input  logic [PAGE_W-1:0]    wr_data,
    output logic [PAGE_W-1:0]    rd_data,
    input  logic [CH_W-1:0]      addr_ch,
    output logic [PAGE_W-1:0]    lo_sel,
    output logic [HI_KEEP_W-1:0] hi_sel
);

    page_state_t state_d, state_q;
    page_array_t hi_view;

    // Next-state: one byte at most changes per cycle.
    always_comb begin
        state_d = state_q;
        if (wr_en && port_map.valid) begin
            if (win_hi) begin
                if (HI_PAGE_EN != 0) begin
                    state_d.hi[port_map.ch] = wr_data;
                end
            end else begin
                state_d.lo[port_map.ch] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    generate
        if (HI_PAGE_EN != 0) begin : g_hi_on
            assign hi_view = state_q.hi;
        end else begin : g_hi_off
            assign hi_view = '0;
        end
    endgenerate

    always_comb begin
        if (!port_map.valid) begin
            rd_data = '0;
        end else if (win_hi) begin
            rd_data = hi_view[port_map.ch];
        end else begin
            rd_data = state_q.lo[port_map.ch];
        end
    end

    always_comb begin
        lo_sel = state_q.lo[addr_ch];
        hi_sel = hi_view[addr_ch][HI_KEEP_W-1:0];
    end

endmodule

// File: rtl/burst_addr_calc.sv
module burst_addr_calc
    import dma_page_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int POS_W  = 16
) (
    input  logic [PAGE_W-1:0]                  lo_page,
    input  logic [HI_KEEP_W-1:0]               hi_page,
    input  logic [ADDR_W-1:0]                  cur_addr,
    input  logic                               dec_mode,
    input  logic [POS_W-1:0]                   xfer_pos,
    input  logic [POS_W-1:0]                   xfer_len,
    output logic [HI_KEEP_W+PAGE_W+ADDR_W-1:0] burst_addr
);

    localparam int PHYS_W = HI_KEEP_W + PAGE_W + ADDR_W;
    localparam int EXT_W  = PHYS_W - POS_W;

    logic [PHYS_W-1:0] phys;
    logic [PHYS_W-1:0] pos_ext;
    logic [PHYS_W-1:0] len_ext;

    always_comb begin
        phys    = {hi_page, lo_page, cur_addr};
        pos_ext = {{EXT_W{1'b0}}, xfer_pos};
        len_ext = {{EXT_W{1'b0}}, xfer_len};
        if (dec_mode) begin
            burst_addr = phys - pos_ext - len_ext;
        end else begin
            burst_addr = phys + pos_ext;
        end
    end

endmodule

// File: rtl/dma_page_addr_gen.sv
module dma_page_addr_gen
    import dma_page_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int POS_W      = 16,
    parameter int HI_PAGE_EN = 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                pg_we,
    input  logic                                pg_sel_hi,
    input  logic [PORT_OFFS_W-1:0]              pg_offs,
    input  logic [PAGE_W-1:0]                   pg_wdata,
    output logic [PAGE_W-1:0]                   pg_rdata,
    input  logic [CH_W-1:0]                     burst_chan,
    input  logic [ADDR_W-1:0]                   cur_addr,
    input  logic                                dec_mode,
    input  logic [POS_W-1:0]                    xfer_pos,
    input  logic [POS_W-1:0]                    xfer_len,
    output logic [HI_KEEP_W+PAGE_W+ADDR_W-1:0]  burst_addr
);

    port_map_t              port_map;
    logic [PAGE_W-1:0]      lo_sel;
    logic [HI_KEEP_W-1:0]   hi_sel;

    page_port_decode u_dec (
        .offs (pg_offs),
        .map  (port_map)
    );

    page_reg_bank #(
        .HI_PAGE_EN (HI_PAGE_EN)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (pg_we),
        .win_hi   (pg_sel_hi),
        .port_map (port_map),
        .wr_data  (pg_wdata),
        .rd_data  (pg_rdata),
        .addr_ch  (burst_chan),
        .lo_sel   (lo_sel),
        .hi_sel   (hi_sel)
    );

    burst_addr_calc #(
        .ADDR_W (ADDR_W),
        .POS_W  (POS_W)
    ) u_calc (
        .lo_page    (lo_sel),
        .hi_page    (hi_sel),
        .cur_addr   (cur_addr),
        .dec_mode   (dec_mode),
        .xfer_pos   (xfer_pos),
        .xfer_len   (xfer_len),
        .burst_addr (burst_addr)
    );

endmodule

// File: rtl/dma_page_addr_chk.sv
module dma_page_addr_chk
    import dma_page_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int POS_W      = 16,
    parameter int HI_PAGE_EN = 1
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               pg_we,
    input logic                               pg_sel_hi,
    input logic [PORT_OFFS_W-1:0]             pg_offs,
    input logic [PAGE_W-1:0]                  pg_wdata,
    input logic [PAGE_W-1:0]                  pg_rdata,
    input logic [ADDR_W-1:0]                  cur_addr,
    input logic                               dec_mode,
    input logic [POS_W-1:0]                   xfer_pos,
    input logic [POS_W-1:0]                   xfer_len,
    input logic [HI_KEEP_W+PAGE_W+ADDR_W-1:0] burst_addr
);

    logic offs_ok;
    logic hi_ok;
    assign offs_ok = (pg_offs == 3'd1) || (pg_offs == 3'd2) ||
                     (pg_offs == 3'd3) || (pg_offs == 3'd7);
    assign hi_ok   = !pg_sel_hi || (HI_PAGE_EN != 0);

    // R3: unmapped offsets read as zero
    a_r3_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !offs_ok |-> (pg_rdata == '0));

    // R4: a stored byte is read back one cycle later on the same port
    a_r4_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_we && offs_ok && hi_ok) |=>
        (($past(pg_offs) != pg_offs) || ($past(pg_sel_hi) != pg_sel_hi) ||
         (pg_rdata == $past(pg_wdata))));

    // R7: increment with zero position keeps the low address bits
    a_r7_inc_zero_pos: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_mode && xfer_pos == '0) |-> (burst_addr[ADDR_W-1:0] == cur_addr));

    // R8: decrement by position and length of zero keeps the low address bits
    a_r8_dec_zero_span: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_mode && xfer_pos == '0 && xfer_len == '0) |->
        (burst_addr[ADDR_W-1:0] == cur_addr));

    generate
        if (HI_PAGE_EN == 0) begin : g_no_hi
            // R9: absent high window reads zero
            a_r9_hi_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
                pg_sel_hi |-> (pg_rdata == '0));
        end
    endgenerate

endmodule

bind dma_page_addr_gen dma_page_addr_chk #(
    .ADDR_W     (ADDR_W),
    .POS_W      (POS_W),
    .HI_PAGE_EN (HI_PAGE_EN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pg_we      (pg_we),
    .pg_sel_hi  (pg_sel_hi),
    .pg_offs    (pg_offs),
    .pg_wdata   (pg_wdata),
    .pg_rdata   (pg_rdata),
    .cur_addr   (cur_addr),
    .dec_mode   (dec_mode),
    .xfer_pos   (xfer_pos),
    .xfer_len   (xfer_len),
    .burst_addr (burst_addr)
);

// File: tb/sim_dma_page_addr_gen.sv
module sim_dma_page_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pg_we = 1'b0;
    logic        pg_sel_hi = 1'b0;
    logic [2:0]  pg_offs = '0;
    logic [7:0]  pg_wdata = '0;
    logic [1:0]  burst_chan = '0;
    logic [15:0] cur_addr = '0;
    logic        dec_mode = 1'b0;
    logic [15:0] xfer_pos = '0;
    logic [15:0] xfer_len = '0;
    logic [7:0]  rdata0, rdata1;
    logic [30:0] addr0, addr1;

    int chk_cnt = 0;
    int fail_cnt = 0;
    bit done = 1'b0;

    logic [7:0] lo_m [4];
    logic [7:0] hi_m [4];

    always #2 clk = ~clk;

    dma_page_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .pg_we(pg_we), .pg_sel_hi(pg_sel_hi),
        .pg_offs(pg_offs), .pg_wdata(pg_wdata), .pg_rdata(rdata0),
        .burst_chan(burst_chan), .cur_addr(cur_addr), .dec_mode(dec_mode),
        .xfer_pos(xfer_pos), .xfer_len(xfer_len), .burst_addr(addr0)
    );

    dma_page_addr_gen #(.HI_PAGE_EN(0)) u1 (
        .clk(clk), .rst_n(rst_n), .pg_we(pg_we), .pg_sel_hi(pg_sel_hi),
        .pg_offs(pg_offs), .pg_wdata(pg_wdata), .pg_rdata(rdata1),
        .burst_chan(burst_chan), .cur_addr(cur_addr), .dec_mode(dec_mode),
        .xfer_pos(xfer_pos), .xfer_len(xfer_len), .burst_addr(addr1)
    );

    // Bench's own view of the port map (R1): -1 marks an unmapped offset.
    function automatic int offs_to_ch(input int offs);
        case (offs)
            7: return 0;
            3: return 1;
            1: return 2;
            2: return 3;
            default: return -1;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        chk_cnt++;
        if (!ok) begin
            fail_cnt++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic page_write(input bit hi, input int offs, input logic [7:0] d);
        int ch;
        @(negedge clk);
        pg_sel_hi = hi;
        pg_offs   = 3'(offs);
        pg_wdata  = d;
        pg_we     = 1'b1;
        @(negedge clk);
        pg_we = 1'b0;
        ch = offs_to_ch(offs);
        if (ch >= 0) begin
            if (hi) hi_m[ch] = d;
            else    lo_m[ch] = d;
        end
    endtask

    task automatic read_sweep(input string req);
        logic [7:0] e0, e1;
        int ch;
        for (int hi = 0; hi < 2; hi++) begin
            for (int offs = 0; offs < 8; offs++) begin
                @(negedge clk);
                pg_sel_hi = hi[0];
                pg_offs   = 3'(offs);
                #1;
                ch = offs_to_ch(offs);
                if (ch < 0) begin
                    e0 = 8'h00;
                    e1 = 8'h00;
                end else if (hi == 1) begin
                    e0 = hi_m[ch];
                    e1 = 8'h00;
                end else begin
                    e0 = lo_m[ch];
                    e1 = lo_m[ch];
                end
                check(rdata0 === e0, req, {24'h0, rdata0}, {24'h0, e0});
                check(rdata1 === e1, {req, " R9"}, {24'h0, rdata1}, {24'h0, e1});
            end
        end
    endtask

    task automatic addr_check(input int ch, input bit dec, input logic [15:0] cur,
                              input logic [15:0] pos, input logic [15:0] len);
        logic [30:0] p0, p1, e0, e1;
        @(negedge clk);
        burst_chan = 2'(ch);
        dec_mode   = dec;
        cur_addr   = cur;
        xfer_pos   = pos;
        xfer_len   = len;
        #1;
        p0 = {hi_m[ch][6:0], lo_m[ch], cur};
        p1 = {7'h00, lo_m[ch], cur};
        if (dec) begin
            e0 = p0 - 31'(pos) - 31'(len);
            e1 = p1 - 31'(pos) - 31'(len);
        end else begin
            e0 = p0 + 31'(pos);
            e1 = p1 + 31'(pos);
        end
        check(addr0 === e0, dec ? "R8 R6 decrement" : "R7 R6 increment",
              {1'b0, addr0}, {1'b0, e0});
        check(addr1 === e1, "R9 no high page in address", {1'b0, addr1}, {1'b0, e1});
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fail_cnt++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            lo_m[i] = 8'h00;
            hi_m[i] = 8'h00;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R5: everything reads zero after reset; R3 unmapped offsets too
        read_sweep("R5 reset state");
        addr_check(2, 1'b0, 16'h1234, 16'h0000, 16'h0000);

        // R1 R2 R4: write every window/offset with distinct bytes
        for (int hi = 0; hi < 2; hi++) begin
            for (int offs = 0; offs < 8; offs++) begin
                page_write(hi[0], offs, 8'(8'h81 + hi * 8'h40 + offs * 8'h13));
            end
        end
        read_sweep("R1 R4 readback");

        // R2: writes to unmapped offsets must leave all pages untouched
        for (int hi = 0; hi < 2; hi++) begin
            page_write(hi[0], 0, 8'hEE);
            page_write(hi[0], 4, 8'hDD);
            page_write(hi[0], 5, 8'hCC);
            page_write(hi[0], 6, 8'hBB);
        end
        read_sweep("R2 R3 unmapped ignored");

        // R6 R7 R8: address sweep over channels, directions, patterns
        for (int ch = 0; ch < 4; ch++) begin
            for (int dec = 0; dec < 2; dec++) begin
                for (int p = 0; p < 5; p++) begin
                    addr_check(ch, dec[0], 16'(ch * 16'h1111 + p * 16'h3C5A),
                               16'(p * 16'h0FFF), 16'(p * 16'h0101 + 1));
                end
            end
        end

        // R7: wrap at the top of the 31-bit space
        page_write(1'b0, 7, 8'hFF);
        page_write(1'b1, 7, 8'hFF);
        addr_check(0, 1'b0, 16'hFFFF, 16'h0001, 16'h0000);
        addr_check(0, 1'b0, 16'hFFF0, 16'hFFFF, 16'h0005);
        // R8: wrap below zero
        page_write(1'b0, 3, 8'h00);
        page_write(1'b1, 3, 8'h00);
        addr_check(1, 1'b1, 16'h0000, 16'h0000, 16'h0001);
        addr_check(1, 1'b1, 16'h0010, 16'h0020, 16'hFFFF);
        // R6: high page bit 7 only, must not reach the address
        page_write(1'b1, 1, 8'h80);
        addr_check(2, 1'b0, 16'hABCD, 16'h0000, 16'h0000);
        read_sweep("R4 final readback");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
        $finish;
    end

endmodule